// File: doc/BRIEF.md
# Multi-Mode Programmable Interval Timer

A synchronous down-counting interval timer with a data latch, a 3-bit mode select and a trigger input. The trigger picks what happens at each rising clock edge. While it is high, the counter takes the latch value. While it is low, the counter counts down. When the count reaches zero, the timer raises a terminal event. The event drives the main output `q` as a level or as a one-clock pulse, in true or inverted polarity. It also toggles the divide-by-two output `qHalf`.

Software or a neighbouring block puts a period into the latch through `dataIn`/`wrEn` and pulses `trig` to start a run. Mode 7 restarts itself at every terminal event, so it gives a periodic pulse train, and `qHalf` becomes a square wave at half that rate. In modes 4 and 5, raising `trig` during a run pauses the count instead of restarting it.

Top module: `interval_timer`

## Requirements
- R1: The latch follows `dataIn` while `wrEn` is low. It keeps the value present at the last clock edge where `wrEn` was low, for as long as `wrEn` stays high. This holds in every mode.
- R2: A rising edge with `trig` high loads the counter from the latch and returns `q` to its inactive level. The exception is modes 4 and 5 while a count is running (see R8). The inactive level is high in modes 1 and 3 and low in all other modes.
- R3: After a load of value L≥1, with `trig` low, the terminal event happens at the L-th following rising edge. `q` shows it immediately after that edge.
- R4: In the level modes 0, 4 and 6, `q` goes high at the terminal event and stays high until the next load. Mode 1 is the same with `q` going low.
- R5: In the pulse modes 2, 5 and 7, `q` is high for exactly one clock after the terminal event. Mode 3 gives the same pulse active low.
- R6: `qHalf` toggles once at every terminal event, in every mode, and is unchanged otherwise.
- R7: In mode 7, each terminal event reloads the counter from the latch. With `trig` low, events then repeat every L clocks without any further trigger.
- R8: In modes 4 and 5, a high `trig` during a running count holds the count. Counting resumes when `trig` falls, so the event comes after the cycles that remained.
- R9: A load of zero leaves the timer idle. No terminal event occurs, `q` stays inactive and `qHalf` is unchanged.
- R10: A synchronous `mrst` clears the counter, the latch and `qHalf`, puts `q` at the inactive level of the current mode, and leaves the timer idle until `trig` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| mrst | input | 1 | Synchronous master reset, active high |
| trig | input | 1 | High: load counter (or hold in modes 4/5 while running); low: count down |
| wrEn | input | 1 | Latch control: low = transparent, high = hold |
| dataIn | input | WIDTH | Period value for the latch |
| mode | input | 3 | Operating mode 0..7 |
| q | output | 1 | Terminal output, level or pulse, polarity set by mode |
| qHalf | output | 1 | Toggles at each terminal event |

## Verification
The assertions assume that `mode` changes only while `mrst` is high. They also assume that `trig` and `wrEn` are already synchronous to `clk`, so the load, hold and count strobes are clean cycle decisions. The bench changes `mode` only together with a reset pulse. It drives every input a short time after a rising edge and samples the outputs at that same point, so no edge sees a changing input. The sweep covers all eight modes across several periods, including the one-clock period. Freeze, latch-hold, zero-load and mid-run reset sequences reuse the same drive discipline.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

  localparam int MODE_W = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // take latch value into counter
    logic dec;     // count down by one
    logic fire;    // this decrement reaches zero
    logic reload;  // auto restart from latch on fire
  } tmr_strobe_t;

  typedef struct packed {
    logic invert;   // q rests high
    logic pulse;    // one-clock pulse instead of level
    logic freeze;   // trig high holds a running count
    logic autoRld;  // restart at terminal event
  } mode_cfg_t;

  function automatic mode_cfg_t decodeMode(input logic [MODE_W-1:0] m);
    mode_cfg_t c;
    c.invert  = (m == 3'd1) || (m == 3'd3);
    c.pulse   = (m == 3'd2) || (m == 3'd3) || (m == 3'd5) || (m == 3'd7);
    c.freeze  = (m == 3'd4) || (m == 3'd5);
    c.autoRld = (m == 3'd7);
    return c;
  endfunction

endpackage

// File: rtl/itimer_datapath.sv
module itimer_datapath
  import itimer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] dataIn,
  input  tmr_strobe_t      strb,
  output logic             cntZero,
  output logic             cntOne,
  output logic [WIDTH-1:0] cntNow
);

  logic [WIDTH-1:0] latchHeld;
  logic [WIDTH-1:0] latchVal;
  logic [WIDTH-1:0] count;

  // latch: transparent while wrEn low, holds last sampled value otherwise
  always_ff @(posedge clk) begin
    if (mrst)       latchHeld <= '0;
    else if (!wrEn) latchHeld <= dataIn;
  end

  assign latchVal = wrEn ? latchHeld : dataIn;

  always_ff @(posedge clk) begin
    if (mrst)                         count <= '0;
    else if (strb.load || strb.reload) count <= latchVal;
    else if (strb.dec)                 count <= count - WIDTH'(1);
  end

  assign cntZero = (count == '0);
  assign cntOne  = (count == WIDTH'(1));
  assign cntNow  = count;

  assert_latch_hold_R1: assert property (@(posedge clk) disable iff (mrst)
    (wrEn && !mrst) |=> (!wrEn || $stable(latchHeld)));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (mrst)
    (strb.dec && !strb.reload) |=> (count == $past(count) - WIDTH'(1)));

endmodule

// File: rtl/itimer_ctrl.sv
module itimer_ctrl
  import itimer_pkg::*;
(
  input  logic              clk,
  input  logic              mrst,
  input  logic              trig,
  input  logic [MODE_W-1:0] mode,
  input  logic              cntZero,
  input  logic              cntOne,
  output tmr_strobe_t       strb,
  output logic              q,
  output logic              qHalf
);

  mode_cfg_t cfg;
  logic      counting;
  logic      hitReg;
  logic      pulseReg;
  logic      halfReg;

  assign cfg      = decodeMode(mode);
  assign counting = !cntZero;

  always_comb begin
    strb.load   = !mrst && trig && !(cfg.freeze && counting);
    strb.dec    = !mrst && !trig && counting;
    strb.fire   = strb.dec && cntOne;
    strb.reload = strb.fire && cfg.autoRld;
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      hitReg   <= 1'b0;
      pulseReg <= 1'b0;
      halfReg  <= 1'b0;
    end else if (strb.load) begin
      hitReg   <= 1'b0;
      pulseReg <= 1'b0;
    end else begin
      pulseReg <= strb.fire;
      if (strb.fire) begin
        hitReg  <= 1'b1;
        halfReg <= ~halfReg;
      end
    end
  end

  assign q     = cfg.invert ^ (cfg.pulse ? pulseReg : hitReg);
  assign qHalf = halfReg;

  assert_load_idle_R2: assert property (@(posedge clk) disable iff (mrst)
    strb.load |=> (q == cfg.invert));

  assert_half_toggle_R6: assert property (@(posedge clk) disable iff (mrst)
    strb.fire |=> (qHalf != $past(qHalf)));

  assert_half_steady_R6: assert property (@(posedge clk) disable iff (mrst)
    !strb.fire |=> $stable(qHalf));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (mrst)
    (pulseReg && !cfg.autoRld) |=> !pulseReg);

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itimer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              trig,
  input  logic              wrEn,
  input  logic [WIDTH-1:0]  dataIn,
  input  logic [MODE_W-1:0] mode,
  output logic              q,
  output logic              qHalf
);

  tmr_strobe_t      strb;
  logic             cntZero;
  logic             cntOne;
  logic [WIDTH-1:0] cntNow;
  mode_cfg_t        cfgTop;

  assign cfgTop = decodeMode(mode);

  itimer_ctrl u_ctrl (
    .clk     (clk),
    .mrst    (mrst),
    .trig    (trig),
    .mode    (mode),
    .cntZero (cntZero),
    .cntOne  (cntOne),
    .strb    (strb),
    .q       (q),
    .qHalf   (qHalf)
  );

  itimer_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .mrst    (mrst),
    .wrEn    (wrEn),
    .dataIn  (dataIn),
    .strb    (strb),
    .cntZero (cntZero),
    .cntOne  (cntOne),
    .cntNow  (cntNow)
  );

  assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (mrst)
    (cfgTop.freeze && trig && !cntZero) |=> $stable(cntNow));

  assert_zero_idle_R9: assert property (@(posedge clk) disable iff (mrst)
    cntZero |-> !strb.fire);

endmodule

// File: tb/interval_timer_bench.sv
module interval_timer_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         mrst = 1'b1;
  logic         trig = 1'b0;
  logic         wrEn = 1'b1;
  logic [W-1:0] dataIn = '0;
  logic [2:0]   mode = 3'd0;
  logic         q;
  logic         qHalf;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  interval_timer #(.WIDTH(W)) u_interval_timer (
    .clk(clk), .mrst(mrst), .trig(trig), .wrEn(wrEn),
    .dataIn(dataIn), .mode(mode), .q(q), .qHalf(qHalf)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit invOf(input int m);
    return (m == 1) || (m == 3);
  endfunction

  function automatic bit pulseOf(input int m);
    return (m == 2) || (m == 3) || (m == 5) || (m == 7);
  endfunction

  task automatic doReset(input int m);
    mode = 3'(m); mrst = 1'b1; trig = 1'b0; wrEn = 1'b1;
    step();
    mrst = 1'b0;
  endtask

  task automatic loadValue(input int v);
    dataIn = W'(v); wrEn = 1'b0; trig = 1'b1;
    step();
    trig = 1'b0; wrEn = 1'b1;
  endtask

  // sweep: one mode, one period
  task automatic runTimer(input int m, input int L);
    bit iv;
    iv = invOf(m);
    doReset(m);
    chk(q == iv, "R10", "q after reset", int'(q), int'(iv));
    chk(qHalf == 1'b0, "R10", "qHalf after reset", int'(qHalf), 0);
    loadValue(L);
    chk(q == iv, "R2", "q after load", int'(q), int'(iv));
    for (int i = 1; i <= L; i++) begin
      step();
      if (i < L) chk(q == iv, "R3", "q before terminal", int'(q), int'(iv));
      else begin
        chk(q == !iv, "R3", "q at terminal", int'(q), int'(!iv));
        chk(qHalf == 1'b1, "R6", "qHalf first toggle", int'(qHalf), 1);
      end
    end
    if (m == 7) begin
      for (int k = L + 1; k <= 2 * L; k++) begin
        step();
        if (k < 2 * L) chk(q == iv, "R7", "q between auto events", int'(q), int'(iv));
        else begin
          chk(q == !iv, "R7", "q at second auto event", int'(q), int'(!iv));
          chk(qHalf == 1'b0, "R6", "qHalf second toggle", int'(qHalf), 0);
        end
      end
    end else begin
      step();
      if (pulseOf(m)) chk(q == iv, "R5", "pulse ended", int'(q), int'(iv));
      else            chk(q == !iv, "R4", "level held", int'(q), int'(!iv));
      chk(qHalf == 1'b1, "R6", "qHalf steady after event", int'(qHalf), 1);
      trig = 1'b1;
      step();
      chk(q == iv, "R2", "q cleared by reload", int'(q), int'(iv));
      trig = 1'b0;
    end
  endtask

  // trig raised mid-count: freeze in modes 4/5, reload otherwise
  task automatic runFreeze(input int m);
    int rem;
    bit iv;
    iv = invOf(m);
    rem = (m == 4 || m == 5) ? 4 : 6;
    doReset(m);
    loadValue(6);
    step(); step();
    trig = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(q == iv, "R8", "q during trig high", int'(q), int'(iv));
    end
    trig = 1'b0;
    for (int i = 1; i <= rem; i++) begin
      step();
      if (i < rem) chk(q == iv, "R8", "q before resumed terminal", int'(q), int'(iv));
      else         chk(q == !iv, "R8", "q at resumed terminal", int'(q), int'(!iv));
    end
  endtask

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step();
    for (int m = 0; m < 8; m++) begin
      runTimer(m, 1);
      runTimer(m, 2);
      runTimer(m, 3);
      runTimer(m, 7);
    end

    runFreeze(4);
    runFreeze(5);
    runFreeze(0);

    // R1: held latch value is used after dataIn changes
    begin
      bit seen;
      doReset(0);
      wrEn = 1'b0; dataIn = W'(3);
      step();
      wrEn = 1'b1;
      step();
      dataIn = W'(9);
      step();
      trig = 1'b1;
      step();
      trig = 1'b0; dataIn = W'(12);
      step(); step();
      chk(q == 1'b0, "R1", "q before held period", int'(q), 0);
      step();
      seen = q;
      chk(seen == 1'b1, "R1", "event at held period 3", int'(seen), 1);
    end

    // R9: zero load stays idle
    begin
      bit bad;
      doReset(2);
      loadValue(0);
      bad = 1'b0;
      for (int i = 0; i < 20; i++) begin
        step();
        if (q != 1'b0 || qHalf != 1'b0) bad = 1'b1;
      end
      chk(!bad, "R9", "idle after zero load", int'(bad), 0);
    end

    // R10: reset mid-run, then idle and latch cleared
    begin
      bit bad;
      doReset(1);
      loadValue(5);
      step(); step();
      mrst = 1'b1;
      step();
      mrst = 1'b0;
      chk(q == 1'b1, "R10", "q inactive after mid reset", int'(q), 1);
      chk(qHalf == 1'b0, "R10", "qHalf cleared", int'(qHalf), 0);
      bad = 1'b0;
      for (int i = 0; i < 10; i++) begin
        step();
        if (q != 1'b1) bad = 1'b1;
      end
      chk(!bad, "R10", "idle until trig", int'(bad), 0);
      trig = 1'b1;
      step();
      trig = 1'b0;
      bad = 1'b0;
      for (int i = 0; i < 10; i++) begin
        step();
        if (q != 1'b1 || qHalf != 1'b0) bad = 1'b1;
      end
      chk(!bad, "R10", "latch cleared gives idle load", int'(bad), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule